// File: doc/BRIEF.md
# Programmable delayed event combiner

This block sits behind the three compare channels of a real-time-clock unit. It takes one raw event pulse from each channel and produces a delayed copy of each pulse, plus one combined event. The whole block runs on the slow counting clock, so every delay is measured in cycles of that clock. A single 4-bit delay code applies to all three channels. It selects a delay from a table that is not linear: the first steps double, and the later steps grow by 16 cycles each, up to 144 cycles.

Each channel has its own down-counter. A raw event starts that counter, and a new raw event while the counter runs starts it again from the full delay. A 3-bit combine mask picks which delayed channel pulses are ORed into the combined output. The delay code and the mask bit are captured when a countdown starts. A change to either of them during a countdown therefore does not affect that countdown.

Top module: `evt_delay_combiner`

## Requirements
- R1: A synchronous active-high reset clears all delayed outputs and the combined output, and abandons any countdown in progress, so that no delayed pulse appears after reset is released.
- R2: With delay code 0, a raw event sampled at a rising edge produces its delayed pulse at the very next rising edge. Code 0 adds no delay beyond the one output register.
- R3: For a raw event sampled at edge k, the delayed pulse is registered at edge k+N. N follows the code table: 1→1, 2→2, 3→4, 4→8, 5→16, 6→32, 7→48, 8→64, 9→80, 10→96, 11→112, 12→128, 13→144.
- R4: Codes 14 and 15 give the maximum delay of 144 cycles.
- R5: The three channels count independently under the one shared code. Each delayed pulse is exactly one cycle wide.
- R6: The combined output is high one cycle after a delayed pulse of a channel whose mask bit was set. Mask bit 0 belongs to channel 0, bit 1 to channel 1 and bit 2 to channel 2. Unselected channels never raise it.
- R7: When the captured mask is all zero, the combined output never fires, while the delayed outputs still pulse.
- R8: A raw event on a channel that is already counting restarts its countdown from the full delay, and the earlier event produces no pulse. This also holds when the new event arrives at the edge where the pulse was due.
- R9: The delay code and mask bit are captured at the edge that starts a countdown. Later changes to them do not alter that countdown's pulse time or its part in the combined output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_evt | input | NUM_CH (3) | Raw compare event pulses, one bit per channel |
| delay_code | input | CODE_W (4) | Shared delay selection code |
| comb_mask | input | NUM_CH (3) | Channel selection for the combined event |
| dly_evt | output | NUM_CH (3) | Delayed one-cycle event pulses |
| comb_evt | output | 1 | Registered OR of the selected delayed pulses |

## Verification
A single event on channel 0 is sent once for each of the sixteen codes. This measures the exact edge of both the delayed and the combined pulse, so an off-by-one in the counter or a wrong table entry shows up as a shifted index. Staggered events on all three channels with a sparse mask show that the counters are independent and that the mask bits line up with the right channels. A zero mask shows that a delayed pulse does not leak into the combined output. Two patterns test the restart rule: a retrigger in mid-count, and a retrigger on the very edge where the pulse is due. A change of code and mask directly after a start tells apart sampling at start from a live read of those inputs. A reset during a countdown checks that the pending pulse is dropped.

// File: rtl/evt_dly_pkg.sv
package evt_dly_pkg;
  // Widths shared by the delay combiner and its checker
  localparam int DEF_NUM_CH  = 3;
  localparam int DEF_CODE_W  = 4;
  localparam int DEF_CNT_W   = 8;
  localparam int DEF_MAX_DLY = 144;
  localparam int DEF_STEP    = 16;

  // Channel countdown state
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;
endpackage

// File: rtl/evt_dly_decode.sv
module evt_dly_decode #(
  parameter int CODE_W  = 4,
  parameter int CNT_W   = 8,
  parameter int MAX_DLY = 144,
  parameter int STEP    = 16
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  cycles_o
);
  // Codes below GEO_START map to themselves, then doubling up to LIN_START,
  // then linear steps of STEP, saturating at MAX_DLY.
  localparam int GEO_START = 3;
  localparam int LIN_START = 6;
  localparam int LIN_BASE  = LIN_START - 2;

  logic [31:0] lin_val;

  always_comb begin
    lin_val  = (32'(code_i) - 32'(LIN_BASE)) * 32'(STEP);
    cycles_o = '0;
    if (code_i < CODE_W'(GEO_START)) begin
      cycles_o = CNT_W'(code_i);
    end else if (code_i < CODE_W'(LIN_START)) begin
      cycles_o = CNT_W'(1) << (code_i - CODE_W'(1));
    end else if (lin_val > 32'(MAX_DLY)) begin
      cycles_o = CNT_W'(MAX_DLY);
    end else begin
      cycles_o = lin_val[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/evt_dly_chan.sv
module evt_dly_chan
  import evt_dly_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             sel_i,
  output logic             pulse_o,
  output logic             sel_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;
  ch_state_e        st_q;
  logic             pulse_q;
  logic             sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      st_q    <= CH_IDLE;
      pulse_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (raw_i) begin
        // A new event always wins: capture settings and (re)start
        sel_q <= sel_i;
        if (load_i == '0) begin
          pulse_q <= 1'b1;
          st_q    <= CH_IDLE;
          cnt_q   <= '0;
        end else begin
          st_q  <= CH_RUN;
          cnt_q <= load_i;
        end
      end else if (st_q == CH_RUN) begin
        if (cnt_q == CNT_W'(1)) begin
          pulse_q <= 1'b1;
          st_q    <= CH_IDLE;
        end
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign pulse_o = pulse_q;
  assign sel_o   = sel_q;
  assign busy_o  = (st_q == CH_RUN);
endmodule

// File: rtl/evt_dly_merge.sv
module evt_dly_merge #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pulse_i,
  input  logic [NUM_CH-1:0] sel_i,
  output logic              comb_o
);
  logic comb_q;

  always_ff @(posedge clk) begin
    if (rst) comb_q <= 1'b0;
    else     comb_q <= |(pulse_i & sel_i);
  end

  assign comb_o = comb_q;
endmodule

// File: rtl/evt_delay_combiner.sv
module evt_delay_combiner
  import evt_dly_pkg::*;
#(
  parameter int NUM_CH  = DEF_NUM_CH,
  parameter int CODE_W  = DEF_CODE_W,
  parameter int CNT_W   = DEF_CNT_W,
  parameter int MAX_DLY = DEF_MAX_DLY,
  parameter int STEP    = DEF_STEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] raw_evt,
  input  logic [CODE_W-1:0] delay_code,
  input  logic [NUM_CH-1:0] comb_mask,
  output logic [NUM_CH-1:0] dly_evt,
  output logic              comb_evt
);
  logic [CNT_W-1:0]  load_cycles;
  logic [NUM_CH-1:0] sel_vec;
  logic [NUM_CH-1:0] busy_vec;

  evt_dly_decode #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W),
    .MAX_DLY(MAX_DLY),
    .STEP   (STEP)
  ) i_decode (
    .code_i  (delay_code),
    .cycles_o(load_cycles)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    evt_dly_chan #(.CNT_W(CNT_W)) i_chan (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_evt[g]),
      .load_i (load_cycles),
      .sel_i  (comb_mask[g]),
      .pulse_o(dly_evt[g]),
      .sel_o  (sel_vec[g]),
      .busy_o (busy_vec[g])
    );
  end

  evt_dly_merge #(.NUM_CH(NUM_CH)) i_merge (
    .clk    (clk),
    .rst    (rst),
    .pulse_i(dly_evt),
    .sel_i  (sel_vec),
    .comb_o (comb_evt)
  );
endmodule

// File: rtl/evt_delay_combiner_chk.sv
module evt_delay_combiner_chk #(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] raw_evt,
  input logic [CODE_W-1:0] delay_code,
  input logic [NUM_CH-1:0] dly_evt,
  input logic              comb_evt,
  input logic [NUM_CH-1:0] sel_vec,
  input logic [NUM_CH-1:0] busy_vec
);
  // R1: outputs are low after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (dly_evt == '0 && !comb_evt));

  // R6: combined pulse only follows a selected delayed pulse
  p_comb_source_r6: assert property (@(posedge clk) disable iff (rst)
    comb_evt |-> $past(|(dly_evt & sel_vec)));

  // R7: nothing selected means no combined pulse next cycle
  p_mask_zero_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_vec == '0) |=> !comb_evt);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // R2: code 0 gives the pulse at the next edge
    p_zero_delay_r2: assert property (@(posedge clk) disable iff (rst)
      (raw_evt[g] && delay_code == '0) |=> dly_evt[g]);

    // R8: a (re)start with nonzero delay never pulses at the next edge
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
      (raw_evt[g] && delay_code != '0) |=> (!dly_evt[g] && busy_vec[g]));

    // R9: captured mask bit is held while counting without a new event
    p_sel_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (busy_vec[g] && !raw_evt[g]) |=> $stable(sel_vec[g]));
  end
endmodule

bind evt_delay_combiner evt_delay_combiner_chk #(
  .NUM_CH(NUM_CH),
  .CODE_W(CODE_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .raw_evt   (raw_evt),
  .delay_code(delay_code),
  .dly_evt   (dly_evt),
  .comb_evt  (comb_evt),
  .sel_vec   (sel_vec),
  .busy_vec  (busy_vec)
);

// File: tb/test_evt_delay_combiner.sv
`timescale 1ns/1ps
module test_evt_delay_combiner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] raw_evt = '0;
  logic [3:0] delay_code = '0;
  logic [2:0] comb_mask = '0;
  logic [2:0] dly_evt;
  logic       comb_evt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // per-run schedule: entry j is driven before rising edge j
  logic [2:0] s_raw  [256];
  logic [3:0] s_code [256];
  logic [2:0] s_mask [256];
  int fd[3];
  int nd[3];
  int fc;
  int nc;

  always #5 clk = ~clk;

  evt_delay_combiner i_evt_delay_combiner (
    .clk(clk), .rst(rst), .raw_evt(raw_evt), .delay_code(delay_code),
    .comb_mask(comb_mask), .dly_evt(dly_evt), .comb_evt(comb_evt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL R1 watchdog expired actual=%0d expected<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dly_of(input int c);
    if (c < 3) return c;
    if (c < 6) return 1 << (c - 1);
    if ((c - 4) * 16 > 144) return 144;
    return (c - 4) * 16;
  endfunction

  task automatic clear_sched(input logic [3:0] code, input logic [2:0] mask);
    for (int j = 0; j < 256; j++) begin
      s_raw[j] = '0; s_code[j] = code; s_mask[j] = mask;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < 3; i++) begin fd[i] = -1; nd[i] = 0; end
    fc = -1; nc = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      raw_evt = s_raw[j]; delay_code = s_code[j]; comb_mask = s_mask[j];
      @(posedge clk); #1;
      for (int i = 0; i < 3; i++) if (dly_evt[i]) begin
        nd[i]++; if (fd[i] < 0) fd[i] = j;
      end
      if (comb_evt) begin nc++; if (fc < 0) fc = j; end
    end
    @(negedge clk); raw_evt = '0;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 dly after reset", int'(dly_evt), 0);
    chk("R1 comb after reset", int'(comb_evt), 0);
    @(negedge clk); rst = 1'b0;
    // start a countdown of 8, then reset mid-way
    clear_sched(4'd4, 3'b111);
    s_raw[1] = 3'b111;
    run(4);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    clear_sched(4'd4, 3'b111);
    run(20);
    chk("R1 no pulse after reset ch0", nd[0], 0);
    chk("R1 no comb after reset", nc, 0);
  endtask

  task automatic test_table();
    for (int c = 0; c < 16; c++) begin
      clear_sched(4'(c), 3'b001);
      s_raw[2] = 3'b001;
      run(2 + dly_of(c) + 4);
      if (c == 0)      chk("R2 zero delay edge", fd[0], 2);
      else if (c < 14) chk($sformatf("R3 code %0d edge", c), fd[0], 2 + dly_of(c));
      else             chk($sformatf("R4 code %0d edge", c), fd[0], 2 + 144);
      chk("R5 pulse width", nd[0], 1);
      chk("R6 comb edge", fc, 3 + dly_of(c));
    end
  endtask

  task automatic test_independent();
    clear_sched(4'd3, 3'b101);
    s_raw[2] = 3'b001; s_raw[5] = 3'b010; s_raw[9] = 3'b100;
    run(20);
    chk("R5 ch0 edge", fd[0], 6);
    chk("R5 ch1 edge", fd[1], 9);
    chk("R5 ch2 edge", fd[2], 13);
    chk("R5 ch1 width", nd[1], 1);
    chk("R6 comb first", fc, 7);
    chk("R6 comb count masks ch1", nc, 2);
  endtask

  task automatic test_mask_zero();
    clear_sched(4'd2, 3'b000);
    s_raw[2] = 3'b111;
    run(10);
    chk("R7 dly still pulses", fd[2], 4);
    chk("R7 comb silent", nc, 0);
  endtask

  task automatic test_restart();
    clear_sched(4'd4, 3'b010);
    s_raw[2] = 3'b010; s_raw[6] = 3'b010;
    run(20);
    chk("R8 mid restart edge", fd[1], 14);
    chk("R8 mid restart count", nd[1], 1);
    clear_sched(4'd4, 3'b010);
    s_raw[2] = 3'b010; s_raw[10] = 3'b010;
    run(24);
    chk("R8 due-edge restart edge", fd[1], 18);
    chk("R8 due-edge restart count", nd[1], 1);
  endtask

  task automatic test_midchange();
    clear_sched(4'd1, 3'b000);
    s_raw[2] = 3'b010; s_code[2] = 4'd5; s_mask[2] = 3'b010;
    run(24);
    chk("R9 start-sampled delay", fd[1], 18);
    chk("R9 start-sampled mask", fc, 19);
  endtask

  initial begin
    test_reset();
    test_table();
    test_independent();
    test_mask_zero();
    test_restart();
    test_midchange();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule